// File: doc/BRIEF.md
# Conversion-to-DMA Request and Overrun Controller

This block sits between a conversion sequencer and a DMA engine. Each finished conversion is captured in a data register, and a DMA request is raised so the engine can move the sample to memory. The request is held until the engine acknowledges it. If a further conversion finishes while the previous sample is still unread, the block sets an overrun flag and blocks all DMA requests. Recovery takes two steps: software writes 1 to the overrun status bit, and the DMA channel is reset through a strobe input.

The block also drives a conversion-enable line back to the sequencer. Software raises it with a start bit. A transfer-complete indication from the DMA engine drops it again, unless the continuous-request bit is set. With that bit set, a circular DMA buffer keeps filling without interruption. Conversions may arrive back to back or one per external trigger, and the request logic serves both patterns.

Top module: `cvt_dma_link`

## Requirements
- R1: After reset, `conv_en`, `dma_req`, `ovr_flag` and `dr_data` are all 0, and both control bits (DMA enable, continuous) are clear.
- R2: A `conv_done` pulse loads `conv_data` into `dr_data` on the same clock edge. If DMA enable (control bit 0) is set and requests are not blocked, `dma_req` is high from the next cycle on.
- R3: `dma_req` stays high until a cycle in which `dma_ack` is high, and goes low after that edge. A `dma_ack` while no request is pending has no effect.
- R4: A `conv_done` while a request is pending and not acknowledged in that cycle sets `ovr_flag` and drops `dma_req` after that edge. `dr_data` takes the new sample. A `conv_done` in the same cycle as an accepted `dma_ack` is not an overrun, and the request stays raised for the new sample.
- R5: While `ovr_flag` is set, or the DMA block latched by an overrun has not yet been reset, `conv_done` raises no request.
- R6: A status write (`stat_we`) with bit 0 = 1 clears `ovr_flag`. With bit 0 = 0 the flag is unchanged. A new overrun in the same cycle as a clear keeps the flag set.
- R7: After an overrun, requests resume only after both the flag clear and a `dma_rst` strobe have been seen, in either order.
- R8: `dma_tc` with the continuous bit (control bit 1) clear drops `conv_en` after that edge. With the continuous bit set, `conv_en` is unaffected.
- R9: A control write with the start bit (control bit 2) set raises `conv_en`, unless requests are blocked, in which case it is ignored. If `dma_tc` stops conversions in the same cycle, the stop wins.
- R10: A control write that clears DMA enable drops a pending `dma_req` after that edge and leaves `ovr_flag` unchanged. While DMA is disabled, `conv_done` raises no request and causes no overrun.
- R11: Conversions on every cycle, each acknowledged in the cycle after its request appears, run without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_done | input | 1 | End-of-conversion pulse from the sequencer |
| conv_data | input | DATA_W | Conversion result, valid with `conv_done` |
| conv_en | output | 1 | Conversions allowed (to the sequencer) |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge; the data register is read in this cycle |
| dma_tc | input | 1 | DMA transfer-complete pulse |
| dma_rst | input | 1 | DMA channel reset strobe |
| dr_data | output | DATA_W | Data register contents |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | bit0 DMA enable, bit1 continuous, bit2 start |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 1 | Write 1 to clear the overrun flag |
| ovr_flag | output | 1 | Overrun status flag |

## Verification
The bench targets the race between `conv_done` and `dma_ack` in the same cycle. A design that ignores the acknowledge there reports a false overrun during back-to-back conversions. A design that honours a late acknowledge misses a real one. It also checks the two-step recovery: a block that resumes after only the flag clear, or only the channel reset, shows a request too early. Finally, it checks that `dma_tc` without the continuous bit stops conversions, that the stop wins over a simultaneous start, and that a start while blocked is ignored. A design that confuses these priorities leaves `conv_en` high where it must be low.

// File: rtl/cvt_dma_pkg.sv
package cvt_dma_pkg;
  localparam int CTRL_W     = 3;
  localparam int CB_DMA_EN  = 0;
  localparam int CB_CONT    = 1;
  localparam int CB_START   = 2;
  localparam int SB_OVR     = 0;

  typedef struct packed {
    logic dma_en;
    logic cont;
  } cvt_cfg_t;
endpackage

// File: rtl/cvt_rst_sync.sv
module cvt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cvt_dr_reg.sv
module cvt_dr_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] dr_q;
  logic [DATA_W-1:0] dr_d;

  always_comb begin
    dr_d = dr_q;
    if (load) dr_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dr_q <= '0;
    else        dr_q <= dr_d;
  end

  assign dout = dr_q;
endmodule

// File: rtl/cvt_cfg_run.sv
module cvt_cfg_run
  import cvt_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              dma_tc,
  input  logic              blocked,
  output cvt_cfg_t          cfg,
  output logic              dis_pulse,
  output logic              conv_en
);
  cvt_cfg_t cfg_q, cfg_d;
  logic     run_q, run_d;
  logic     start_hit;
  logic     tc_stop;

  always_comb begin
    start_hit = ctrl_we && ctrl_wdata[CB_START] && !blocked;
    tc_stop   = dma_tc && !cfg_q.cont;
    dis_pulse = ctrl_we && !ctrl_wdata[CB_DMA_EN];

    cfg_d = cfg_q;
    if (ctrl_we) begin
      cfg_d.dma_en = ctrl_wdata[CB_DMA_EN];
      cfg_d.cont   = ctrl_wdata[CB_CONT];
    end

    run_d = run_q;
    if (tc_stop)        run_d = 1'b0;
    else if (start_hit) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      run_q <= run_d;
    end
  end

  assign cfg     = cfg_q;
  assign conv_en = run_q;
endmodule

// File: rtl/cvt_req_ovr.sv
module cvt_req_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic dma_en,
  input  logic dis_pulse,
  input  logic dma_ack,
  input  logic dma_rst,
  input  logic ovr_clr,
  output logic dma_req,
  output logic ovr_flag,
  output logic blocked
);
  logic pend_q, pend_d;
  logic ovr_q, ovr_d;
  logic blk_q, blk_d;
  logic taken;
  logic overrun;
  logic accept;

  always_comb begin
    blocked = ovr_q || blk_q;
    taken   = pend_q && dma_ack;
    overrun = conv_done && pend_q && !taken;
    accept  = conv_done && dma_en && !blocked;

    ovr_d = ovr_q;
    if (overrun)      ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;

    blk_d = blk_q;
    if (overrun)      blk_d = 1'b1;
    else if (dma_rst) blk_d = 1'b0;

    pend_d = pend_q;
    if (dis_pulse)             pend_d = 1'b0;
    else if (overrun)          pend_d = 1'b0;
    else if (accept)           pend_d = 1'b1;
    else if (taken || dma_rst) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
      blk_q  <= blk_d;
    end
  end

  assign dma_req  = pend_q;
  assign ovr_flag = ovr_q;
endmodule

// File: rtl/cvt_dma_link.sv
module cvt_dma_link
  import cvt_dma_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_en,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic              dma_tc,
  input  logic              dma_rst,
  output logic [DATA_W-1:0] dr_data,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              stat_we,
  input  logic              stat_wdata,
  output logic              ovr_flag
);
  logic     rst_n_sync;
  cvt_cfg_t cfg;
  logic     dis_pulse;
  logic     blocked;
  logic     ovr_clr;

  assign ovr_clr = stat_we && stat_wdata;

  cvt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cvt_dr_reg #(.DATA_W(DATA_W)) u_dr (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (conv_done),
    .din   (conv_data),
    .dout  (dr_data)
  );

  cvt_cfg_run u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .dma_tc     (dma_tc),
    .blocked    (blocked),
    .cfg        (cfg),
    .dis_pulse  (dis_pulse),
    .conv_en    (conv_en)
  );

  cvt_req_ovr u_req (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .conv_done (conv_done),
    .dma_en    (cfg.dma_en),
    .dis_pulse (dis_pulse),
    .dma_ack   (dma_ack),
    .dma_rst   (dma_rst),
    .ovr_clr   (ovr_clr),
    .dma_req   (dma_req),
    .ovr_flag  (ovr_flag),
    .blocked   (blocked)
  );
endmodule

// File: rtl/cvt_dma_link_chk.sv
module cvt_dma_link_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              conv_done,
  input logic [DATA_W-1:0] conv_data,
  input logic              conv_en,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              dma_tc,
  input logic              dma_rst,
  input logic [DATA_W-1:0] dr_data,
  input logic              ctrl_we,
  input logic [2:0]        ctrl_wdata,
  input logic              cont,
  input logic              ovr_flag
);
  a_r2_dr_load: assert property (@(posedge clk) disable iff (!rst_n_sync)
    conv_done |=> dr_data == $past(conv_data));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n_sync)
    dma_req && !dma_ack && !conv_done && !dma_rst && !(ctrl_we && !ctrl_wdata[0]) |=> dma_req);

  a_r4_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n_sync)
    conv_done && dma_req && !dma_ack |=> ovr_flag && !dma_req);

  a_r5_no_req_flagged: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ovr_flag |-> !dma_req);

  a_r6_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(ovr_flag) |-> $past(conv_done));

  a_r8_tc_stop: assert property (@(posedge clk) disable iff (!rst_n_sync)
    dma_tc && !cont |=> !conv_en);

  a_r10_disable_drop: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ctrl_we && !ctrl_wdata[0] |=> !dma_req && ovr_flag == $past(ovr_flag));
endmodule

bind cvt_dma_link cvt_dma_link_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .conv_done  (conv_done),
  .conv_data  (conv_data),
  .conv_en    (conv_en),
  .dma_req    (dma_req),
  .dma_ack    (dma_ack),
  .dma_tc     (dma_tc),
  .dma_rst    (dma_rst),
  .dr_data    (dr_data),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .cont       (cfg.cont),
  .ovr_flag   (ovr_flag)
);

// File: tb/cvt_dma_link_tb.sv
module cvt_dma_link_tb;
  localparam int DW = 12;

  logic          clk;
  logic          rst_n;
  logic          conv_done, dma_ack, dma_tc, dma_rst, ctrl_we, stat_we, stat_wdata;
  logic [DW-1:0] conv_data;
  logic [2:0]    ctrl_wdata;
  logic          conv_en, dma_req, ovr_flag;
  logic [DW-1:0] dr_data;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_en, m_cont, m_run, m_pend, m_ovr, m_blk;
  int m_dr;

  cvt_dma_link #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .conv_en(conv_en), .dma_req(dma_req), .dma_ack(dma_ack), .dma_tc(dma_tc),
    .dma_rst(dma_rst), .dr_data(dr_data), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .ovr_flag(ovr_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_cont = 0; m_run = 0; m_pend = 0; m_ovr = 0; m_blk = 0; m_dr = 0;
    end else begin
      bit blk_now, took, orun, nen, ncont, nrun, npend, novr, nblk;
      blk_now = m_ovr || m_blk;
      took    = m_pend && dma_ack;
      orun    = conv_done && m_pend && !took;
      novr    = orun ? 1'b1 : ((stat_we && stat_wdata) ? 1'b0 : m_ovr);
      nblk    = orun ? 1'b1 : (dma_rst ? 1'b0 : m_blk);
      if (ctrl_we && !ctrl_wdata[0])             npend = 0;
      else if (orun)                             npend = 0;
      else if (conv_done && m_en && !blk_now)    npend = 1;
      else if (took || dma_rst)                  npend = 0;
      else                                       npend = m_pend;
      if (dma_tc && !m_cont)                         nrun = 0;
      else if (ctrl_we && ctrl_wdata[2] && !blk_now) nrun = 1;
      else                                           nrun = m_run;
      nen   = ctrl_we ? ctrl_wdata[0] : m_en;
      ncont = ctrl_we ? ctrl_wdata[1] : m_cont;
      if (conv_done) m_dr = int'(conv_data);
      m_en = nen; m_cont = ncont; m_run = nrun; m_pend = npend; m_ovr = novr; m_blk = nblk;
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 dma_req vs model",  int'(dma_req),  int'(m_pend));
      chk("R4 ovr_flag vs model", int'(ovr_flag), int'(m_ovr));
      chk("R8 conv_en vs model",  int'(conv_en),  int'(m_run));
      chk("R2 dr_data vs model",  int'(dr_data),  m_dr);
    end
  end

  task automatic tick();
    @(negedge clk);
    conv_done = 0; dma_ack = 0; dma_tc = 0; dma_rst = 0; ctrl_we = 0; stat_we = 0;
    stat_wdata = 0;
  endtask

  task automatic wr_ctrl(input bit en, input bit cont, input bit start);
    ctrl_we = 1; ctrl_wdata = {start, cont, en}; tick();
  endtask

  task automatic conv(input int d, input bit ack);
    conv_done = 1; conv_data = DW'(d); dma_ack = ack; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; conv_done = 0; conv_data = '0; dma_ack = 0; dma_tc = 0; dma_rst = 0;
    ctrl_we = 0; ctrl_wdata = '0; stat_we = 0; stat_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk("R1 conv_en", int'(conv_en), 0);
    chk("R1 dma_req", int'(dma_req), 0);
    chk("R1 ovr_flag", int'(ovr_flag), 0);
    chk("R1 dr_data", int'(dr_data), 0);
    // R10 disabled DMA: no request, no overrun
    conv(7, 0); conv(8, 0);
    chk("R10 no req while disabled", int'(dma_req), 0);
    chk("R10 no ovr while disabled", int'(ovr_flag), 0);
    // R9 start
    wr_ctrl(1, 0, 1);
    chk("R9 start raises conv_en", int'(conv_en), 1);
    // R2 capture and request
    conv(12'h5A3, 0);
    chk("R2 req after conv", int'(dma_req), 1);
    chk("R2 data captured", int'(dr_data), 12'h5A3);
    // R3 hold and ack
    tick(); tick();
    chk("R3 req held", int'(dma_req), 1);
    dma_ack = 1; tick();
    chk("R3 ack clears req", int'(dma_req), 0);
    dma_ack = 1; tick();
    chk("R3 stray ack ignored", int'(dma_req), 0);
    // R11 back to back with ack in same cycle as next conversion
    conv(1, 0);
    for (int i = 2; i < 10; i++) conv(i, 1);
    chk("R11 no overrun back-to-back", int'(ovr_flag), 0);
    chk("R11 req for last sample", int'(dma_req), 1);
    dma_ack = 1; tick();
    // R11 trigger-spaced conversions
    for (int i = 0; i < 4; i++) begin
      conv(100 + i, 0); tick(); dma_ack = 1; tick(); tick();
    end
    chk("R11 triggered mode no overrun", int'(ovr_flag), 0);
    // R4 overrun
    conv(20, 0); conv(21, 0);
    chk("R4 ovr set", int'(ovr_flag), 1);
    chk("R4 req dropped", int'(dma_req), 0);
    chk("R4 new data kept", int'(dr_data), 21);
    // R5 blocked
    conv(22, 0);
    chk("R5 no req while flagged", int'(dma_req), 0);
    // R6 clear behaviour
    stat_we = 1; stat_wdata = 0; tick();
    chk("R6 write 0 keeps flag", int'(ovr_flag), 1);
    stat_we = 1; stat_wdata = 1; tick();
    chk("R6 write 1 clears flag", int'(ovr_flag), 0);
    // R7 still blocked until channel reset
    conv(23, 0);
    chk("R7 blocked until dma_rst", int'(dma_req), 0);
    dma_rst = 1; tick();
    conv(24, 0);
    chk("R7 resumes after both", int'(dma_req), 1);
    dma_ack = 1; tick();
    // R8 transfer complete stops
    dma_tc = 1; tick();
    chk("R8 tc stops conv_en", int'(conv_en), 0);
    wr_ctrl(1, 1, 1);
    dma_tc = 1; tick();
    chk("R8 continuous keeps conv_en", int'(conv_en), 1);
    // R9 stop wins over start
    wr_ctrl(1, 0, 0);
    ctrl_we = 1; ctrl_wdata = 3'b101; dma_tc = 1; tick();
    chk("R9 tc beats start", int'(conv_en), 0);
    // R9 start ignored while blocked
    conv(30, 0); conv(31, 0);
    wr_ctrl(1, 0, 1);
    chk("R9 start ignored when blocked", int'(conv_en), 0);
    stat_we = 1; stat_wdata = 1; tick();
    dma_rst = 1; tick();
    wr_ctrl(1, 0, 1);
    chk("R9 start after recovery", int'(conv_en), 1);
    // R10 disable drops request, keeps flag
    conv(40, 0);
    chk("R10 pending before disable", int'(dma_req), 1);
    wr_ctrl(0, 0, 0);
    chk("R10 disable drops req", int'(dma_req), 0);
    chk("R10 flag unchanged", int'(ovr_flag), 0);
    repeat (3) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule